// File: doc/BRIEF.md
# Sliding-Window Sum of Absolute Differences Unit

This block serves the motion-estimation datapath. It takes two 128-bit operands. Each operand carries sixteen unsigned 8-bit pixels. From the reference operand it picks a four-pixel template. From the search operand it picks a run of eleven consecutive pixels. The template is compared against the run at eight positions, each one pixel further along than the last. Each comparison yields a sum of four absolute differences. The eight sums are packed as 16-bit lanes into a single 128-bit result.

A 3-bit field of the mode input chooses which part of each operand is used. Bits [1:0] place the template, and bit 2 places the start of the search run. The operands are accepted in any cycle where `in_valid` is high. The result appears from a register one cycle later and stays there until the next accepted operation.

Byte i of an operand occupies bits [8i+7:8i].

Top module: `slide_sad8`

## Requirements
- R1: For k = 0..7, result lane k (bits [16k+15:16k]) equals the sum over j = 0..3 of |x(j) − y(k+j)|. Here x is the template and y is the search run.
- R2: If mode bit 2 is 0, search run y(0..10) is bytes 0..10 of `srch_b`. If mode bit 2 is 1, it is bytes 4..14.
- R3: Mode bits [1:0] = n select template x(0..3) as bytes 4n..4n+3 of `ref_a`.
- R4: All pixels are unsigned. Each absolute difference is an unsigned magnitude. A lane never exceeds 1020, and its upper bits are zero. An all-0xFF operand against an all-zero operand gives 1020 in every lane.
- R5: Mode bits [7:3] have no effect on the result.
- R6: `out_valid` is high in the cycle after a cycle in which `in_valid` was sampled high. Otherwise it is low.
- R7: While `in_valid` is low, `out_sums` keeps its last value, whatever happens on `ref_a`, `srch_b` and `mode`.
- R8: A synchronous active-high `rst` clears `out_valid` and `out_sums` to zero at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and mode are accepted this cycle |
| ref_a | input | 128 | Reference operand (template side), 16 bytes |
| srch_b | input | 128 | Search operand (sliding side), 16 bytes |
| mode | input | 8 | Bits [1:0] template offset, bit 2 search base, bits [7:3] ignored |
| out_valid | output | 1 | Result register loaded in the previous cycle |
| out_sums | output | 128 | Eight 16-bit sums, lane k at bits [16k+15:16k] |

## Verification
Several properties are checked on every cycle:
- `out_valid` follows an accepted input by exactly one cycle.
- The result register holds while no input is accepted.
- Reset clears the output.
- The registered lanes match the combinational sums of the cycle before.
- No lane exceeds 1020.
- The selected offsets stay inside the operands.

Some things only the bench scenarios can show. These are whether each lane has the right value for a given template and search placement, and whether the upper mode bits leave the result alone. The bench covers these with flat, saturated, alternating, ramp and random operands under every mode value.

// File: rtl/slide_sad_pkg.sv
package slide_sad_pkg;
  localparam int PIX_W   = 8;
  localparam int NPIX    = 16;
  localparam int REF_LEN = 4;
  localparam int NSUMS   = 8;
  localparam int SUM_W   = 16;
  localparam int MODE_W  = 8;

  typedef logic [PIX_W-1:0] pix_t;

  // unsigned magnitude of the difference of two pixels
  function automatic pix_t abs_diff(input pix_t a, input pix_t b);
    return (a > b) ? pix_t'(a - b) : pix_t'(b - a);
  endfunction

  // widen a pixel into a sum lane
  function automatic logic [SUM_W-1:0] widen(input pix_t p);
    return {{(SUM_W-PIX_W){1'b0}}, p};
  endfunction
endpackage

// File: rtl/ssad_window_sel.sv
module ssad_window_sel
  import slide_sad_pkg::*;
#(
  parameter int P_PIX_W   = PIX_W,
  parameter int P_NPIX    = NPIX,
  parameter int P_REF_LEN = REF_LEN,
  parameter int P_NSUMS   = NSUMS,
  localparam int DATA_W   = P_PIX_W * P_NPIX,
  localparam int SPAN     = P_NSUMS + P_REF_LEN - 1,
  localparam int OFF_W    = $clog2(P_NPIX) + 1
) (
  input  logic [DATA_W-1:0]            ref_vec,
  input  logic [DATA_W-1:0]            srch_vec,
  input  logic [1:0]                   tmpl_sel,
  input  logic                         base_sel,
  output logic [P_REF_LEN*P_PIX_W-1:0] tmpl_win,
  output logic [SPAN*P_PIX_W-1:0]      srch_win,
  output logic [OFF_W-1:0]             tmpl_off,
  output logic [OFF_W-1:0]             srch_off
);
  // the template offset steps in whole template widths
  assign tmpl_off = OFF_W'(int'(tmpl_sel) * P_REF_LEN);

  // the search base is either zero or one template width
  assign srch_off = base_sel ? OFF_W'(P_REF_LEN) : '0;

  for (genvar j = 0; j < P_REF_LEN; j++) begin : g_tmpl
    assign tmpl_win[j*P_PIX_W +: P_PIX_W] =
      ref_vec[(int'(tmpl_off) + j) * P_PIX_W +: P_PIX_W];
  end

  for (genvar i = 0; i < SPAN; i++) begin : g_srch
    assign srch_win[i*P_PIX_W +: P_PIX_W] =
      srch_vec[(int'(srch_off) + i) * P_PIX_W +: P_PIX_W];
  end
endmodule

// File: rtl/ssad_lane.sv
module ssad_lane
  import slide_sad_pkg::*;
#(
  parameter int P_PIX_W   = PIX_W,
  parameter int P_REF_LEN = REF_LEN,
  parameter int P_SUM_W   = SUM_W,
  localparam int WIN_W    = P_PIX_W * P_REF_LEN
) (
  input  logic [WIN_W-1:0]   tmpl,
  input  logic [WIN_W-1:0]   seg,
  output logic [P_SUM_W-1:0] sum
);
  // one named magnitude per pixel pair
  logic [P_PIX_W-1:0] mag_w [P_REF_LEN];

  for (genvar j = 0; j < P_REF_LEN; j++) begin : g_mag
    assign mag_w[j] = abs_diff(tmpl[j*P_PIX_W +: P_PIX_W], seg[j*P_PIX_W +: P_PIX_W]);
  end

  always_comb begin
    sum = '0;
    for (int j = 0; j < P_REF_LEN; j++) begin
      sum = sum + P_SUM_W'(widen(mag_w[j]));
    end
  end
endmodule

// File: rtl/ssad_out_reg.sv
module ssad_out_reg #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic         q_valid,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q       <= '0;
    end else begin
      q_valid <= load;
      if (load) q <= d;
    end
  end

  // R6
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> q_valid);

  // R6
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> !q_valid);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!q_valid && q == '0));
endmodule

// File: rtl/slide_sad8.sv
module slide_sad8
  import slide_sad_pkg::*;
#(
  parameter int P_PIX_W   = PIX_W,
  parameter int P_NPIX    = NPIX,
  parameter int P_REF_LEN = REF_LEN,
  parameter int P_NSUMS   = NSUMS,
  parameter int P_SUM_W   = SUM_W,
  parameter int P_MODE_W  = MODE_W,
  localparam int DATA_W   = P_PIX_W * P_NPIX,
  localparam int OUT_W    = P_SUM_W * P_NSUMS,
  localparam int SPAN     = P_NSUMS + P_REF_LEN - 1,
  localparam int WIN_W    = P_PIX_W * P_REF_LEN,
  localparam int OFF_W    = $clog2(P_NPIX) + 1,
  localparam int LANE_MAX = P_REF_LEN * ((1 << P_PIX_W) - 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [DATA_W-1:0]   ref_a,
  input  logic [DATA_W-1:0]   srch_b,
  input  logic [P_MODE_W-1:0] mode,
  output logic                out_valid,
  output logic [OUT_W-1:0]    out_sums
);
  // mode decode: bits above 2 take no part
  logic [1:0] tmpl_sel_w;
  logic       base_sel_w;
  assign tmpl_sel_w = mode[1:0];
  assign base_sel_w = mode[2];

  logic [WIN_W-1:0]        tmpl_win_w;
  logic [SPAN*P_PIX_W-1:0] srch_win_w;
  logic [OFF_W-1:0]        tmpl_off_w;
  logic [OFF_W-1:0]        srch_off_w;
  logic [OUT_W-1:0]        lane_sums_w;

  ssad_window_sel #(
    .P_PIX_W  (P_PIX_W),
    .P_NPIX   (P_NPIX),
    .P_REF_LEN(P_REF_LEN),
    .P_NSUMS  (P_NSUMS)
  ) u_sel (
    .ref_vec (ref_a),
    .srch_vec(srch_b),
    .tmpl_sel(tmpl_sel_w),
    .base_sel(base_sel_w),
    .tmpl_win(tmpl_win_w),
    .srch_win(srch_win_w),
    .tmpl_off(tmpl_off_w),
    .srch_off(srch_off_w)
  );

  for (genvar k = 0; k < P_NSUMS; k++) begin : g_lane
    ssad_lane #(
      .P_PIX_W  (P_PIX_W),
      .P_REF_LEN(P_REF_LEN),
      .P_SUM_W  (P_SUM_W)
    ) u_lane (
      .tmpl(tmpl_win_w),
      .seg (srch_win_w[k*P_PIX_W +: WIN_W]),
      .sum (lane_sums_w[k*P_SUM_W +: P_SUM_W])
    );
  end

  ssad_out_reg #(.W(OUT_W)) u_out (
    .clk    (clk),
    .rst    (rst),
    .load   (in_valid),
    .d      (lane_sums_w),
    .q_valid(out_valid),
    .q      (out_sums)
  );

  // R2
  srch_range_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(srch_off_w) + SPAN) <= P_NPIX);

  // R3
  tmpl_range_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(tmpl_off_w) + P_REF_LEN) <= P_NPIX);

  // R1
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_sums == $past(lane_sums_w)));

  for (genvar k = 0; k < P_NSUMS; k++) begin : g_bound
    // R4
    lane_bound_chk: assert property (@(posedge clk) disable iff (rst)
      int'(out_sums[k*P_SUM_W +: P_SUM_W]) <= LANE_MAX);
  end
endmodule

// File: tb/slide_sad8_tb.sv
module slide_sad8_tb;
  localparam int NPAT = 6;
  localparam logic [127:0] PAT_A [NPAT] = '{
    128'h0,
    {16{8'hFF}},
    {8{16'hAA55}},
    128'h0F0E0D0C0B0A09080706050403020100,
    128'h80_7F_01_FE_40_C0_20_E0_11_22_33_44_99_88_77_66,
    {16{8'hFF}}
  };
  localparam logic [127:0] PAT_B [NPAT] = '{
    128'h0,
    {16{8'hFF}},
    {8{16'h55AA}},
    128'hF0E1D2C3B4A5968778695A4B3C2D1E0F,
    128'h01_02_03_04_05_06_07_08_09_0A_0B_0C_0D_0E_0F_10,
    128'h0
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] ref_a = '0;
  logic [127:0] srch_b = '0;
  logic [7:0]   mode = '0;
  logic         out_valid;
  logic [127:0] out_sums;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  slide_sad8 u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .ref_a(ref_a), .srch_b(srch_b), .mode(mode),
    .out_valid(out_valid), .out_sums(out_sums)
  );

  // behavioural reference, written from the requirements
  function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                         input logic [7:0] m);
    logic [127:0] r = '0;
    int xo = 4 * int'(m[1:0]);
    int yo = m[2] ? 4 : 0;
    for (int k = 0; k < 8; k++) begin
      int s = 0;
      for (int j = 0; j < 4; j++) begin
        int d = int'(a[8*(xo+j) +: 8]) - int'(b[8*(yo+k+j) +: 8]);
        s += (d < 0) ? -d : d;
      end
      r[16*k +: 16] = 16'(s);
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one operation and sample its result one cycle later
  task automatic apply(input logic [127:0] a, input logic [127:0] b, input logic [7:0] m,
                       input string req);
    logic [127:0] e = model(a, b, m);
    @(negedge clk);
    ref_a = a; srch_b = b; mode = m; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, {req, " out_valid"}, 128'(out_valid), 128'd1);
    check(out_sums === e, req, out_sums, e);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [127:0] held;
    repeat (3) @(negedge clk);
    // R8 reset state
    check(out_valid === 1'b0, "R8 reset valid", 128'(out_valid), 128'd0);
    check(out_sums === '0, "R8 reset sums", out_sums, 128'd0);
    rst = 1'b0;

    // R1 R2 R3 pattern table over every mode value
    for (int p = 0; p < NPAT; p++) begin
      for (int m = 0; m < 8; m++) begin
        apply(PAT_A[p], PAT_B[p], 8'(m), "R1 R2 R3 table");
      end
    end

    // R4 saturated against zero: every lane is 1020
    apply({16{8'hFF}}, 128'h0, 8'h5, "R4 max");
    check(out_sums === {8{16'd1020}}, "R4 max lanes", out_sums, {8{16'd1020}});
    apply(128'h0, {16{8'hFF}}, 8'h2, "R4 unsigned reverse");

    // R1 random operands
    for (int n = 0; n < 40; n++) begin
      apply({$urandom, $urandom, $urandom, $urandom},
            {$urandom, $urandom, $urandom, $urandom}, 8'($urandom), "R1 random");
    end

    // R5 upper mode bits ignored
    for (int m = 0; m < 8; m++) begin
      logic [127:0] a = {$urandom, $urandom, $urandom, $urandom};
      logic [127:0] b = {$urandom, $urandom, $urandom, $urandom};
      apply(a, b, {5'b10110, 3'(m)}, "R5 high bits");
      check(out_sums === model(a, b, 8'(m)), "R5 equal to low-bits mode",
            out_sums, model(a, b, 8'(m)));
    end

    // R6 R7 no accept: valid drops, result held while inputs wander
    apply(PAT_A[4], PAT_B[4], 8'h3, "R6 setup");
    held = model(PAT_A[4], PAT_B[4], 8'h3);
    @(negedge clk);
    ref_a = ~ref_a; srch_b = {16{8'h5A}}; mode = 8'h7;
    check(out_valid === 1'b0, "R6 idle valid", 128'(out_valid), 128'd0);
    repeat (3) @(negedge clk);
    check(out_sums === held, "R7 hold", out_sums, held);
    check(out_valid === 1'b0, "R6 still idle", 128'(out_valid), 128'd0);

    // R6 back-to-back accepts
    @(negedge clk);
    ref_a = PAT_A[3]; srch_b = PAT_B[3]; mode = 8'h1; in_valid = 1'b1;
    @(negedge clk);
    check(out_sums === model(PAT_A[3], PAT_B[3], 8'h1), "R6 first of pair",
          out_sums, model(PAT_A[3], PAT_B[3], 8'h1));
    mode = 8'h6;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, "R6 second valid", 128'(out_valid), 128'd1);
    check(out_sums === model(PAT_A[3], PAT_B[3], 8'h6), "R6 second of pair",
          out_sums, model(PAT_A[3], PAT_B[3], 8'h6));

    // R8 reset mid-run clears a held result
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R8 mid reset valid", 128'(out_valid), 128'd0);
    check(out_sums === '0, "R8 mid reset sums", out_sums, 128'd0);
    rst = 1'b0;
    apply(PAT_A[2], PAT_B[2], 8'h4, "R8 after reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule